// File: doc/BRIEF.md
# DMA Transmit Filler-Stripping Realigner

This block sits between a packet FIFO and a host-bound DMA path. The FIFO delivers each packet as 32-bit words in big-endian byte order. The first byte of the packet is in bits [31:24], and the first two bytes of every packet are filler that was inserted upstream for header alignment. The block removes those two bytes and repacks the rest into 32-bit little-endian words for the host. Because the filler is half a word, every output word takes its first half from one input word and its second half from the next. The block therefore holds two bytes in a carry register between input beats.

The final input beat of a packet can leave one or two bytes in the carry register. When that happens, the block emits one extra short word to flush them. Each output word carries a valid-byte count, and the unused lanes of a short word are zero. A running byte total for the host counts only the bytes the host actually receives, so the filler is never included. Both sides use a valid/ready handshake. When the host side stalls, the FIFO side is held off and the carried bytes are kept.

Top module: `dma_tx_unpad`

## Requirements
- R1: For a packet of L bytes (L >= 3), the output byte stream is exactly packet bytes 2 through L-1 in order. Packet bytes 0 and 1 never appear.
- R2: Input words are big-endian, so packet byte 4w+k is in in_data[31-8k -: 8] of beat w. Output words are little-endian, so payload byte 4m+j is in out_data[8j+7:8j] of output word m.
- R3: out_bytes is 4 on every output word except the last one of a packet. The last word has ((L-3) mod 4)+1 bytes. Lanes at or above out_bytes are zero.
- R4: out_last is high only on the final output word of a packet. A packet yields exactly ceil((L-2)/4) output words.
- R5: While out_valid is high and out_ready is low, out_data, out_last and out_bytes hold their values and out_valid stays high.
- R6: in_ready is low whenever out_valid is high and out_ready is low. Stalls on either side lose no bytes.
- R7: host_byte_count grows by out_bytes on every accepted output word and is unchanged otherwise, so it counts payload bytes only.
- R8: After reset, out_valid is low, in_ready is high and host_byte_count is zero.
- R9: On the input side, every beat except the last is a full 4 bytes. in_bytes gives the valid count (1 to 4) on the beat that has in_last high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | FIFO word available |
| in_ready | output | 1 | Block accepts the FIFO word this cycle |
| in_data | input | 32 | Big-endian packet word, filler included |
| in_last | input | 1 | Final word of the packet |
| in_bytes | input | 3 | Valid bytes in the final word (1..4) |
| out_valid | output | 1 | Host word available |
| out_ready | input | 1 | Host side accepts the word |
| out_data | output | 32 | Little-endian payload word |
| out_last | output | 1 | Final host word of the packet |
| out_bytes | output | 3 | Valid bytes in out_data (1..4) |
| host_byte_count | output | 32 | Running total of payload bytes delivered |

## Verification
The hardest case to reach is the extra flush word. It appears only when the final input beat holds three or four bytes, and it must then survive a host stall while the FIFO side is frozen. The bench sweeps packet lengths over every remainder modulo 4, including the shortest packets, where the flush word is the only output. It repeats each length with a pseudo-random pattern on out_ready and on input gaps, so stalls land on the flush cycle and on carry-holding cycles.

// File: rtl/dmatx_pkg.sv
package dmatx_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int HALF   = LANES / 2;
  localparam int BCNT_W = $clog2(LANES + 1);
  typedef logic [BCNT_W-1:0] bcnt_t;
endpackage

// File: rtl/dmatx_bytecnt.sv
module dmatx_bytecnt
  import dmatx_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  bcnt_t            nbytes,
  output logic [CNT_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (rst)
      total <= '0;
    else if (fire)
      total <= total + CNT_W'(nbytes);
  end

  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(total));
endmodule

// File: rtl/dmatx_realign.sv
module dmatx_realign
  import dmatx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  bcnt_t             in_bytes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output bcnt_t             out_bytes
);
  localparam int CARRY_W = HALF * BYTE_W;

  logic [CARRY_W-1:0] carry_q;
  logic               first_q;
  logic               flush_q;
  bcnt_t              flush_cnt_q;

  logic               slot_free;
  logic               take;
  logic [WORD_W-1:0]  joined;
  logic [WORD_W-1:0]  flushed;
  bcnt_t              join_cnt;
  logic [WORD_W-1:0]  join_masked;
  logic [WORD_W-1:0]  flush_masked;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = slot_free && !flush_q;
  assign take      = in_valid && in_ready;

  // Lane j of a host word: carried bytes fill the low half, the new
  // beat's leading bytes fill the high half, oldest byte in lane 0.
  for (genvar j = 0; j < HALF; j++) begin : g_lane
    assign joined[j*BYTE_W +: BYTE_W]         = carry_q[CARRY_W-1-j*BYTE_W -: BYTE_W];
    assign joined[(HALF+j)*BYTE_W +: BYTE_W]  = in_data[WORD_W-1-j*BYTE_W -: BYTE_W];
    assign flushed[j*BYTE_W +: BYTE_W]        = carry_q[CARRY_W-1-j*BYTE_W -: BYTE_W];
    assign flushed[(HALF+j)*BYTE_W +: BYTE_W] = '0;
  end

  always_comb begin
    if (in_last && (in_bytes <= bcnt_t'(HALF)))
      join_cnt = bcnt_t'(HALF) + in_bytes;
    else
      join_cnt = bcnt_t'(LANES);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    assign join_masked[j*BYTE_W +: BYTE_W]  =
      (bcnt_t'(j) < join_cnt) ? joined[j*BYTE_W +: BYTE_W] : '0;
    assign flush_masked[j*BYTE_W +: BYTE_W] =
      (bcnt_t'(j) < flush_cnt_q) ? flushed[j*BYTE_W +: BYTE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_last    <= 1'b0;
      out_bytes   <= '0;
      carry_q     <= '0;
      first_q     <= 1'b1;
      flush_q     <= 1'b0;
      flush_cnt_q <= '0;
    end else begin
      if (out_valid && out_ready)
        out_valid <= 1'b0;
      if (flush_q && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= flush_masked;
        out_last  <= 1'b1;
        out_bytes <= flush_cnt_q;
        flush_q   <= 1'b0;
        first_q   <= 1'b1;
      end else if (take) begin
        carry_q <= in_data[CARRY_W-1:0];
        if (first_q) begin
          if (in_last) begin
            if (in_bytes > bcnt_t'(HALF)) begin
              flush_q     <= 1'b1;
              flush_cnt_q <= in_bytes - bcnt_t'(HALF);
            end
          end else begin
            first_q <= 1'b0;
          end
        end else begin
          out_valid <= 1'b1;
          out_data  <= join_masked;
          out_bytes <= join_cnt;
          if (in_last && (in_bytes <= bcnt_t'(HALF))) begin
            out_last <= 1'b1;
            first_q  <= 1'b1;
          end else if (in_last) begin
            out_last    <= 1'b0;
            flush_q     <= 1'b1;
            flush_cnt_q <= in_bytes - bcnt_t'(HALF);
          end else begin
            out_last <= 1'b0;
          end
        end
      end
    end
  end

  // R5
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_bytes)));
  // R6
  stall_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R3
  full_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_bytes == bcnt_t'(LANES)));
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_bytes != '0) && (out_bytes <= bcnt_t'(LANES))));
endmodule

// File: rtl/dma_tx_unpad.sv
module dma_tx_unpad
  import dmatx_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [BCNT_W-1:0] in_bytes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic [BCNT_W-1:0] out_bytes,
  output logic [CNT_W-1:0]  host_byte_count
);
  dmatx_realign u_align (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_bytes  (in_bytes),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_bytes (out_bytes)
  );

  dmatx_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .fire   (out_valid && out_ready),
    .nbytes (out_bytes),
    .total  (host_byte_count)
  );
endmodule

// File: tb/sim_dma_tx_unpad.sv
module sim_dma_tx_unpad;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [2:0]  in_bytes = 3'd4;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_last;
  logic [2:0]  out_bytes;
  logic [31:0] host_byte_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] lf = 8'h5a;
  logic [7:0] pb [0:299];
  logic [7:0] ob [0:299];

  always #5 clk = ~clk;

  dma_tx_unpad u0 (.*);

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pkt(input int len, input int seed, input bit bp);
    int nw = (len + 3) / 4;
    int widx = 0;
    int nob = 0;
    int nlast = 0;
    int nwords = 0;
    int lastcnt = 0;
    int cyc = 0;
    bit done = 0;
    bit lanes_ok = 1;
    bit full_ok = 1;
    bit bytes_ok = 1;
    logic [31:0] cnt0 = host_byte_count;
    int exp_pay = len - 2;
    for (int i = 0; i < len; i++) pb[i] = 8'((seed + i * 37 + (i >> 2)) & 8'hff);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = bp ? (lf[0] | lf[3]) : 1'b1;
      if (widx < nw) begin
        in_valid = bp ? (lf[1] | lf[6]) : 1'b1;
        in_last  = (widx == nw - 1);
        in_bytes = in_last ? 3'(len - 4 * (nw - 1)) : 3'd4;
        for (int k = 0; k < 4; k++)
          in_data[31 - 8 * k -: 8] = (4 * widx + k < len) ? pb[4 * widx + k] : 8'h00;
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      #1;
      if (in_valid && in_ready) widx++;
      if (out_valid && out_ready) begin
        nwords++;
        for (int j = 0; j < 4; j++) begin
          if (j < out_bytes) begin
            if (nob < 300) ob[nob] = out_data[8 * j +: 8];
            nob++;
          end else if (out_data[8 * j +: 8] != 8'h00) lanes_ok = 0;
        end
        if (out_last) begin
          nlast++;
          lastcnt = out_bytes;
          done = 1;
        end else if (out_bytes != 3'd4) full_ok = 0;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check($sformatf("R4 len=%0d finished", len), done, done, 1);
    check($sformatf("R1 len=%0d payload size", len), nob == exp_pay, nob, exp_pay);
    for (int i = 0; i < exp_pay && i < nob; i++)
      if (ob[i] != pb[i + 2]) bytes_ok = 0;
    // R2: byte order via lane position of each payload byte
    check($sformatf("R1 R2 len=%0d byte order", len), bytes_ok, bytes_ok, 1);
    check($sformatf("R4 len=%0d word count", len), nwords == (exp_pay + 3) / 4 && nlast == 1,
          nwords, (exp_pay + 3) / 4);
    check($sformatf("R3 len=%0d tail count", len), lastcnt == ((len - 3) % 4) + 1,
          lastcnt, ((len - 3) % 4) + 1);
    check($sformatf("R3 len=%0d full words and zero lanes", len), full_ok && lanes_ok,
          full_ok && lanes_ok, 1);
    check($sformatf("R7 len=%0d host count", len), host_byte_count - cnt0 == 32'(exp_pay),
          host_byte_count - cnt0, exp_pay);
  endtask

  task automatic test_reset;
    // R8
    check("R8 out_valid after reset", out_valid == 1'b0, out_valid, 0);
    check("R8 in_ready after reset", in_ready == 1'b1, in_ready, 1);
    check("R8 counter after reset", host_byte_count == 0, host_byte_count, 0);
  endtask

  task automatic test_sweep_free;
    // R9 inputs: full beats then a tail of 1..4 bytes
    for (int len = 3; len <= 14; len++) run_pkt(len, len * 11, 1'b0);
    run_pkt(64, 3, 1'b0);
  endtask

  task automatic test_sweep_stall;
    // R5 R6 stalls on both sides
    for (int len = 3; len <= 14; len++) run_pkt(len, len * 5 + 1, 1'b1);
    run_pkt(127, 9, 1'b1);
    run_pkt(200, 77, 1'b1);
  endtask

  task automatic test_hold;
    int n = 0;
    // R5 R6: word held under a host stall, input blocked
    logic [31:0] d0;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b0; in_bytes = 3'd4; in_data = 32'hAABB0102;
    @(negedge clk);
    in_data = 32'h03040506;
    @(negedge clk);
    in_last = 1'b1; in_bytes = 3'd4; in_data = 32'h0708090A;
    @(negedge clk);
    d0 = out_data;
    check("R2 first host word", out_valid && d0 == 32'h04030201, d0, 32'h04030201);
    check("R6 input held while stalled", in_ready == 1'b0, in_ready, 0);
    repeat (3) @(negedge clk);
    check("R5 word stable", out_valid && out_data == d0, out_data, d0);
    out_ready = 1'b1;
    while (n < 10) begin
      #1;
      if (in_valid && in_ready) in_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    check("R7 counter after hold packet", host_byte_count != 0, host_byte_count, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset;
    test_sweep_free;
    test_sweep_stall;
    test_hold;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule